// File: doc/BRIEF.md
# Packet Checksum Accumulator

This block adds up the bytes of a packet into a running checksum that wraps modulo 2^W. A `run_i` level marks the packet: it is high for the whole packet and low between packets. A `newdata_i` strobe marks each clock cycle that carries a byte to be added. The running total appears on `result_o` after each byte. When `run_i` falls, `done_o` rises and `result_o` keeps the final checksum, so that an external comparator can check it against the checksum the sender transmitted.

The block holds a sum register and a separate result register. The sum register is fed by a two-way multiplexer. Select 0 loads zero, and select 1 loads the adder output. Each of the two registers has its own load enable. A two-state controller, idle or accumulating, drives the select and the load enables. When a new packet starts, the controller clears the sum. The result register still shows the previous checksum until the first byte of the new packet is added.

Top module: `chksum_accum`

## Requirements
- R1: A synchronous active-high reset `rst` gives `done_o`=1 and `result_o`=0 after the next rising edge, and it clears the internal sum.
- R2: While `run_i`=0, `done_o` is 1 after the next edge and `result_o` keeps its value. `newdata_i` and `data_i` have no effect while `run_i`=0.
- R3: The first rising edge with `run_i`=1 after idle makes `done_o`=0 and clears the sum to zero.
- R4: On each edge with `run_i`=1 and `newdata_i`=1 in the accumulating state, the sum and `result_o` both become the old sum plus `data_i`. For example, the bytes 03, 06, 04, 02 give 03, 09, 0D, 0F.
- R5: On an edge with `run_i`=1 and `newdata_i`=0 in the accumulating state, the sum and `result_o` do not change.
- R6: When a new packet starts, `result_o` keeps the previous packet's checksum until the first new byte arrives. That byte then replaces it, because it is added to the cleared sum. For example, 0F is held, and 07 appears after the byte 07.
- R7: The addition is modulo 2^W, and any carry out of the top bit is dropped. For example, F7 + 0A gives 01 with W=8.
- R8: A byte presented with `newdata_i`=1 on the same edge where `run_i` first goes high is added to zero. `result_o` then equals that byte and `done_o` becomes 0.
- R9: All outputs come from registers and change only on the rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | High for the duration of a packet |
| newdata_i | input | 1 | Qualifies `data_i` as a byte to add |
| data_i | input | W | Byte to accumulate |
| result_o | output | W | Registered running checksum |
| done_o | output | 1 | High while idle; the checksum is final |

## Verification
Two functions can fall in the same cycle: clearing the sum when a packet starts, and adding a byte. The bench provokes this by raising `run_i` and `newdata_i` on the same edge. It judges the outcome by checking that `result_o` equals the byte alone and is not the byte plus the stale sum. A second collision is `run_i` falling while `newdata_i` is still high. Here the bench requires that the checksum is frozen and that `done_o` rises.

// File: rtl/chksum_accum.sv
module chksum_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_i,
  input  logic         newdata_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);

  typedef enum logic {ST_IDLE, ST_ACC} st_t;

  st_t          st_q;
  logic [W-1:0] sum_q, res_q;
  logic [W-1:0] base, sum_d;
  logic         busy, mux_sel, sum_ld, res_ld;

  assign busy    = (st_q == ST_ACC);
  assign mux_sel = newdata_i;
  assign base    = busy ? sum_q : '0;
  assign sum_d   = mux_sel ? base + data_i : '0;
  assign sum_ld  = run_i & (newdata_i | ~busy);
  assign res_ld  = run_i & newdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      sum_q <= '0;
      res_q <= '0;
    end else begin
      st_q <= run_i ? ST_ACC : ST_IDLE;
      if (sum_ld) sum_q <= sum_d;
      if (res_ld) res_q <= sum_d;
    end
  end

  assign result_o = res_q;
  assign done_o   = (st_q == ST_IDLE);

endmodule

// File: rtl/chksum_accum_chk.sv
module chksum_accum_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         newdata,
  input logic [W-1:0] data,
  input logic [W-1:0] result,
  input logic         done,
  input logic [W-1:0] sum
);

  logic [W-1:0] exp_add;
  assign exp_add = sum + data;

  a_r1_reset: assert property (@(posedge clk) rst |=> (done && result == '0 && sum == '0));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> (done && $stable(result) && $stable(sum)));

  a_r3_start_clear: assert property (@(posedge clk) disable iff (rst)
    (done && run && !newdata) |=> (!done && sum == '0));

  a_r4_add: assert property (@(posedge clk) disable iff (rst)
    (!done && run && newdata) |=> (result == $past(exp_add) && sum == $past(exp_add)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!done && run && !newdata) |=> ($stable(result) && $stable(sum)));

  a_r6_keep_prev: assert property (@(posedge clk) disable iff (rst)
    (done && run && !newdata) |=> $stable(result));

  a_r8_first_byte: assert property (@(posedge clk) disable iff (rst)
    (done && run && newdata) |=> (!done && result == $past(data)));

endmodule

bind chksum_accum chksum_accum_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run(run_i), .newdata(newdata_i), .data(data_i),
  .result(result_o), .done(done_o), .sum(sum_q)
);

// File: tb/chksum_accum_test.sv
module chksum_accum_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run = 1'b0;
  logic         nd  = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] result;
  logic         done;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           finished = 1'b0;

  always #2.5 clk = ~clk;

  chksum_accum #(.W(W)) uut (
    .clk(clk), .rst(rst), .run_i(run), .newdata_i(nd), .data_i(data),
    .result_o(result), .done_o(done)
  );

  task automatic check(string req, logic [W-1:0] exp_r, logic exp_d);
    n_chk++;
    if (result !== exp_r || done !== exp_d) begin
      n_bad++;
      $display("FAIL %s: result=%02h done=%0b expected result=%02h done=%0b",
               req, result, done, exp_r, exp_d);
    end
  endtask

  task automatic step(logic r, logic n, logic [W-1:0] d);
    run = r; nd = n; data = d;
    @(posedge clk);
    #1;
    n_chk++;
    if (result !== uut.result_o) n_bad++;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1'b1, 1'b1, 8'h5A);
    check("R1 reset", 8'h00, 1'b1);
    rst = 1'b0;
    step(1'b0, 1'b0, 8'h00);
    check("R2 idle after reset", 8'h00, 1'b1);
  endtask

  task automatic t_packet();
    step(1'b1, 1'b0, 8'h03); check("R3 start", 8'h00, 1'b0);
    step(1'b1, 1'b1, 8'h03); check("R4 add 03", 8'h03, 1'b0);
    step(1'b1, 1'b1, 8'h06); check("R4 add 06", 8'h09, 1'b0);
    step(1'b1, 1'b1, 8'h04); check("R4 add 04", 8'h0D, 1'b0);
    step(1'b1, 1'b1, 8'h02); check("R4 add 02", 8'h0F, 1'b0);
    step(1'b1, 1'b0, 8'h02); check("R5 hold", 8'h0F, 1'b0);
    step(1'b1, 1'b0, 8'hEE); check("R5 hold other data", 8'h0F, 1'b0);
    step(1'b0, 1'b0, 8'h02); check("R2 done", 8'h0F, 1'b1);
    step(1'b0, 1'b1, 8'h55); check("R2 newdata ignored", 8'h0F, 1'b1);
  endtask

  task automatic t_new_packet();
    step(1'b1, 1'b0, 8'h07); check("R6 prev held", 8'h0F, 1'b0);
    step(1'b1, 1'b0, 8'h07); check("R6 prev still held", 8'h0F, 1'b0);
    step(1'b1, 1'b1, 8'h07); check("R6 first byte on cleared sum", 8'h07, 1'b0);
  endtask

  task automatic t_wrap();
    step(1'b1, 1'b1, 8'hF0); check("R7 no carry yet", 8'hF7, 1'b0);
    step(1'b1, 1'b1, 8'h0A); check("R7 wrap", 8'h01, 1'b0);
    step(1'b1, 1'b1, 8'hFF); check("R7 add FF", 8'h00, 1'b0);
    step(1'b0, 1'b0, 8'h00); check("R2 done after wrap", 8'h00, 1'b1);
  endtask

  task automatic t_same_cycle();
    step(1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'h22); check("R8 start and byte", 8'h22, 1'b0);
    step(1'b1, 1'b1, 8'h11); check("R8 next byte", 8'h33, 1'b0);
    step(1'b0, 1'b1, 8'h44); check("R2 stop with newdata", 8'h33, 1'b1);
    step(1'b1, 1'b1, 8'h10); check("R8 restart with byte", 8'h10, 1'b0);
  endtask

  task automatic t_edge_only();
    run = 1'b0; nd = 1'b0; data = 8'h00;
    @(negedge clk);
    run = 1'b1; nd = 1'b1; data = 8'h99;
    #1; check("R9 no change before edge", 8'h10, 1'b1);
    @(posedge clk); #1;
    check("R9 change at edge", 8'h99, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_packet();
    t_new_packet();
    t_wrap();
    t_same_cycle();
    step(1'b0, 1'b0, 8'h00);
    t_edge_only();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: result=%02h done=%0b expected completion", result, done);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule